// File: doc/BRIEF.md
# Dual-Channel PLL Lock Monitor

This block watches two frequency-synthesizer channels from the reference-oscillator clock domain. Every reference period it checks whether each channel's divider pulse arrived close enough to the reference-divider pulse. A channel is declared locked only after a run of good periods. One lock pin then reports a selectable view of the two channel states.

The pin can show either channel alone, the AND of both, or a forced low level. A channel held in standby always reads as locked. A test mode reuses the same pin to bring out the raw reference pulse, either raw channel pulse, or the oscillator divided by two.

The pin is open-drain, so the block drives a pull-low enable rather than a level. All divider pulses are one clock wide and synchronous to the oscillator clock.

Top module: `pll_lock_monitor`

## Requirements
- R1: A synchronous active-high reset clears both lock states, the consecutive-cycle counts, the divider history and the divide-by-two flop. On the clock after reset, `pull_low` is 1.
- R2: A channel pulse is in-window for a reference pulse when their clock edges differ by fewer than `WIN` oscillator periods. With `WIN` = 2 this means an offset of -1, 0 or +1 cycles. An offset of ±2 is out of window.
- R3: A channel becomes locked on the evaluation that completes more than `LOCK_CYCLES` consecutive in-window reference periods. With the default of 3 this is the fourth. After only `LOCK_CYCLES` good periods the channel is not locked.
- R4: One out-of-window period clears that channel's lock and restarts its count from zero. A reference period with no channel pulse in the window counts as out-of-window.
- R5: With `test_en` = 0, a channel whose standby bit is 1 reads as locked in every selection. `sb[0]` is channel 1 and `sb[1]` is channel 2.
- R6: With `test_en` = 0, `sel` picks the view. `sel[1]` is the first selection bit and `sel[0]` the second. Code 00 shows channel 1 AND channel 2, 01 shows channel 2, 10 shows channel 1, and 11 shows a constant low level.
- R7: With `test_en` = 1, `sel` = 00 shows `ref_pulse`, 01 shows `ch_pulse[1]`, 10 shows `ch_pulse[0]`, and 11 shows a flop that toggles on every clock after reset.
- R8: `pull_low` is registered and equals the inverse of the selected level. It changes one clock after the lock state or the input that decides it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference-oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_pulse | input | 1 | One-clock pulse from the reference divider |
| ch_pulse | input | 2 | One-clock pulses from the channel dividers; bit 0 is channel 1 |
| sb | input | 2 | Standby bits; bit 0 is channel 1 |
| sel | input | 2 | Output selection; bit 1 is the first selection bit |
| test_en | input | 1 | Test-mode enable |
| pull_low | output | 1 | Open-drain enable; 1 pulls the lock pin low |

## Verification
The bench builds the block with `WIN` = 2 and `LOCK_CYCLES` = 3. With these values the window edge sits at ±1 versus ±2 cycles, and the lock threshold falls on the fourth good period. A reference period of twelve clocks therefore reaches locking, a single-miss reset, a relock and every selection code within a few hundred cycles. The behavioural model works from pulse timestamps rather than shift registers, so offsets of -1, +1 and ±2 probe both sides of the window in both directions.

// File: rtl/lkm_pkg.sv
package lkm_pkg;
  localparam int NCH = 2;

  typedef enum logic [1:0] {
    SEL_BOTH = 2'b00,
    SEL_CH2  = 2'b01,
    SEL_CH1  = 2'b10,
    SEL_OFF  = 2'b11
  } sel_t;
endpackage

// File: rtl/lkm_window.sv
// Decides, one evaluation per reference pulse, whether the channel pulse
// fell inside +/-(WIN-1) clocks of it. Evaluation lands WIN-1 clocks after
// the reference pulse so that late channel pulses are still seen.
module lkm_window #(
  parameter int WIN = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_pulse,
  input  logic ch_pulse,
  output logic eval,
  output logic hit
);
  localparam int LAG  = WIN - 1;
  localparam int HIST = 2 * LAG;

  logic [LAG-1:0]  ref_sh;
  logic [HIST-1:0] ch_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_sh <= '0;
      ch_sh  <= '0;
    end else begin
      ref_sh <= LAG'({ref_sh, ref_pulse});
      ch_sh  <= HIST'({ch_sh, ch_pulse});
    end
  end

  assign eval = ref_sh[LAG-1];
  assign hit  = ch_pulse | (|ch_sh);
endmodule

// File: rtl/lkm_qualify.sv
// Counts consecutive in-window evaluations; lock after more than LOCK_CYCLES.
module lkm_qualify #(
  parameter int LOCK_CYCLES = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic eval,
  input  logic hit,
  output logic locked
);
  localparam int NEED = LOCK_CYCLES + 1;
  localparam int CW   = $clog2(NEED + 1);
  localparam logic [CW-1:0] NEED_V = CW'(NEED);

  logic [CW-1:0] run;

  always_ff @(posedge clk) begin
    if (rst) begin
      run    <= '0;
      locked <= 1'b0;
    end else if (eval) begin
      if (!hit) begin
        run    <= '0;
        locked <= 1'b0;
      end else if (run != NEED_V) begin
        run <= run + 1'b1;
        if (run == NEED_V - 1'b1) locked <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/lkm_outsel.sv
module lkm_outsel
  import lkm_pkg::*;
(
  input  logic [NCH-1:0] locked,
  input  logic [NCH-1:0] sb,
  input  sel_t           sel,
  input  logic           test_en,
  input  logic           ref_pulse,
  input  logic [NCH-1:0] ch_pulse,
  input  logic           half_osc,
  output logic           level
);
  logic [NCH-1:0] eff;

  assign eff = locked | sb;

  always_comb begin
    if (test_en) begin
      unique case (sel)
        SEL_BOTH: level = ref_pulse;
        SEL_CH2:  level = ch_pulse[1];
        SEL_CH1:  level = ch_pulse[0];
        default:  level = half_osc;
      endcase
    end else begin
      unique case (sel)
        SEL_BOTH: level = &eff;
        SEL_CH2:  level = eff[1];
        SEL_CH1:  level = eff[0];
        default:  level = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/pll_lock_monitor.sv
module pll_lock_monitor
  import lkm_pkg::*;
#(
  parameter int WIN         = 2,
  parameter int LOCK_CYCLES = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ref_pulse,
  input  logic [1:0] ch_pulse,
  input  logic [1:0] sb,
  input  logic [1:0] sel,
  input  logic       test_en,
  output logic       pull_low
);
  logic [NCH-1:0] win_eval;
  logic [NCH-1:0] win_hit;
  logic [NCH-1:0] ch_locked;
  logic           half_osc;
  logic           level;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    lkm_window #(.WIN(WIN)) u_win (
      .clk       (clk),
      .rst       (rst),
      .ref_pulse (ref_pulse),
      .ch_pulse  (ch_pulse[c]),
      .eval      (win_eval[c]),
      .hit       (win_hit[c])
    );
    lkm_qualify #(.LOCK_CYCLES(LOCK_CYCLES)) u_qual (
      .clk    (clk),
      .rst    (rst),
      .eval   (win_eval[c]),
      .hit    (win_hit[c]),
      .locked (ch_locked[c])
    );
  end

  lkm_outsel u_sel (
    .locked    (ch_locked),
    .sb        (sb),
    .sel       (sel_t'(sel)),
    .test_en   (test_en),
    .ref_pulse (ref_pulse),
    .ch_pulse  (ch_pulse),
    .half_osc  (half_osc),
    .level     (level)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      half_osc <= 1'b0;
      pull_low <= 1'b1;
    end else begin
      half_osc <= ~half_osc;
      pull_low <= ~level;
    end
  end
endmodule

// File: rtl/lkm_checker.sv
module lkm_checker
  import lkm_pkg::*;
(
  input logic           clk,
  input logic           rst,
  input logic [1:0]     sb,
  input logic [1:0]     sel,
  input logic           test_en,
  input logic           pull_low,
  input logic [NCH-1:0] eval,
  input logic [NCH-1:0] hit,
  input logic [NCH-1:0] locked
);
  p_reset_out_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> pull_low);

  p_const_low_r6: assert property (@(posedge clk) disable iff (rst)
    (!test_en && sel == 2'b11) |=> pull_low);

  p_standby_high_r5: assert property (@(posedge clk) disable iff (rst)
    (!test_en && sb == 2'b11 && sel != 2'b11) |=> !pull_low);

  p_half_osc_r7: assert property (@(posedge clk) disable iff (rst)
    (test_en && sel == 2'b11 && $past(test_en && sel == 2'b11) && !$past(rst))
      |=> (pull_low != $past(pull_low)));

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    p_miss_clears_r4: assert property (@(posedge clk) disable iff (rst)
      (eval[c] && !hit[c]) |=> !locked[c]);

    p_hold_between_r3: assert property (@(posedge clk) disable iff (rst)
      !eval[c] |=> $stable(locked[c]));

    p_lock_on_hit_r2: assert property (@(posedge clk) disable iff (rst)
      $rose(locked[c]) |-> $past(eval[c] && hit[c]));
  end
endmodule

bind pll_lock_monitor lkm_checker u_chk (
  .clk      (clk),
  .rst      (rst),
  .sb       (sb),
  .sel      (sel),
  .test_en  (test_en),
  .pull_low (pull_low),
  .eval     (win_eval),
  .hit      (win_hit),
  .locked   (ch_locked)
);

// File: tb/pll_lock_monitor_bench.sv
module pll_lock_monitor_bench;
  localparam int WIN    = 2;
  localparam int LOCKC  = 3;
  localparam int LAG    = WIN - 1;
  localparam int PER    = 12;
  localparam int SLOT   = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ref_pulse = 1'b0;
  logic [1:0] ch_pulse = 2'b00;
  logic [1:0] sb = 2'b00;
  logic [1:0] sel = 2'b10;
  logic       test_en = 1'b0;
  logic       pull_low;

  pll_lock_monitor #(.WIN(WIN), .LOCK_CYCLES(LOCKC)) u_pll_lock_monitor (
    .clk(clk), .rst(rst), .ref_pulse(ref_pulse), .ch_pulse(ch_pulse),
    .sb(sb), .sel(sel), .test_en(test_en), .pull_low(pull_low)
  );

  always #10 clk = ~clk;

  int    n_cmp = 0;
  int    n_bad = 0;
  string cur_req = "R1";

  // behavioural model: timestamps of last pulses
  int cyc = 0;
  int ref_at = -1000;
  int ch_last [2] = '{-1000, -1000};
  int run [2] = '{0, 0};
  bit lk [2] = '{0, 0};
  bit div2 = 0;
  bit exp_pl = 1;
  bit started = 0;

  function automatic bit model_level();
    bit e1, e2;
    e1 = lk[0] || sb[0];
    e2 = lk[1] || sb[1];
    if (test_en) begin
      if (sel == 2'b00) return ref_pulse;
      if (sel == 2'b01) return ch_pulse[1];
      if (sel == 2'b10) return ch_pulse[0];
      return div2;
    end
    if (sel == 2'b00) return e1 && e2;
    if (sel == 2'b01) return e2;
    if (sel == 2'b10) return e1;
    return 1'b0;
  endfunction

  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      exp_pl = 1; div2 = 0; ref_at = -1000;
      for (int c = 0; c < 2; c++) begin
        ch_last[c] = -1000; run[c] = 0; lk[c] = 0;
      end
    end else begin
      exp_pl = !model_level();
      for (int c = 0; c < 2; c++) if (ch_pulse[c]) ch_last[c] = cyc;
      if (cyc == ref_at + LAG) begin
        for (int c = 0; c < 2; c++) begin
          if (ch_last[c] >= ref_at - LAG) begin
            if (run[c] < LOCKC + 1) run[c]++;
            lk[c] = (run[c] > LOCKC);
          end else begin
            run[c] = 0; lk[c] = 0;
          end
        end
      end
      if (ref_pulse) ref_at = cyc;
      div2 = !div2;
    end
    cyc++;
  end

  always @(negedge clk) begin
    if (started) begin
      n_cmp++;
      if (pull_low !== exp_pl) begin
        n_bad++;
        $display("FAIL %s: pull_low=%0b expected %0b at cycle %0d", cur_req, pull_low, exp_pl, cyc);
      end
    end
  end

  task automatic check_pl(input string req, input bit expv);
    n_cmp++;
    if (pull_low !== expv) begin
      n_bad++;
      $display("FAIL %s: pull_low=%0b expected %0b (directed)", req, pull_low, expv);
    end
  endtask

  // nr reference periods; channel c pulses at SLOT+off unless miss
  task automatic periods(input int nr, input int o1, input int o2, input bit m1, input bit m2);
    for (int p = 0; p < nr; p++) begin
      for (int k = 0; k < PER; k++) begin
        ref_pulse   = (k == SLOT);
        ch_pulse[0] = !m1 && (k == SLOT + o1);
        ch_pulse[1] = !m2 && (k == SLOT + o2);
        @(negedge clk);
      end
    end
    ref_pulse = 0; ch_pulse = 2'b00;
  endtask

  initial begin
    #(20 * 100000);
    n_bad++;
    $display("FAIL watchdog: finished=0 expected 1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  bit prev;

  initial begin
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check_pl("R1", 1'b1);

    cur_req = "R3";
    periods(3, 0, 0, 0, 1);
    check_pl("R3", 1'b1);   // only LOCK_CYCLES good periods
    periods(1, 0, 0, 0, 1);
    check_pl("R3", 1'b0);   // fourth good period locks

    cur_req = "R2";
    periods(2, 1, 0, 0, 1);
    check_pl("R2", 1'b0);   // +1 in window
    periods(2, -1, 0, 0, 1);
    check_pl("R2", 1'b0);   // -1 in window
    periods(1, 2, 0, 0, 1);
    check_pl("R2", 1'b1);   // +2 out of window
    periods(4, -1, 0, 0, 1);
    check_pl("R2", 1'b0);
    periods(1, -2, 0, 0, 1);
    check_pl("R2", 1'b1);   // -2 out of window

    cur_req = "R4";
    periods(4, 0, 0, 0, 1);
    check_pl("R4", 1'b0);
    periods(1, 0, 0, 1, 1);
    check_pl("R4", 1'b1);   // missing pulse clears lock
    periods(3, 0, 0, 0, 1);
    check_pl("R4", 1'b1);   // count restarted
    periods(1, 0, 0, 0, 1);
    check_pl("R4", 1'b0);

    cur_req = "R6";
    sel = 2'b00;
    periods(4, 0, 0, 0, 0);
    check_pl("R6", 1'b0);   // both locked, AND view
    periods(1, 0, 0, 1, 0);
    check_pl("R6", 1'b1);   // ch1 lost
    sel = 2'b01;
    periods(1, 0, 0, 0, 0);
    check_pl("R6", 1'b0);   // ch2 view
    sel = 2'b10;
    periods(1, 0, 0, 0, 0);
    check_pl("R6", 1'b1);   // ch1 view, not yet relocked
    sel = 2'b11;
    periods(1, 0, 0, 0, 0);
    check_pl("R6", 1'b1);
    sel = 2'b10;
    periods(1, 0, 0, 0, 0);
    check_pl("R6", 1'b0);   // ch1 relocked
    sel = 2'b11;
    periods(1, 0, 0, 0, 0);
    check_pl("R6", 1'b1);   // constant low while locked

    cur_req = "R5";
    sel = 2'b10; sb = 2'b01;
    periods(2, 0, 0, 1, 0);
    check_pl("R5", 1'b0);   // ch1 unlocked but in standby
    sb = 2'b00;
    @(negedge clk);
    check_pl("R5", 1'b1);
    sb = 2'b11; sel = 2'b00;
    periods(1, 0, 0, 1, 1);
    check_pl("R5", 1'b0);
    sb = 2'b00;

    cur_req = "R7";
    test_en = 1; sel = 2'b11;
    repeat (3) @(negedge clk);
    prev = pull_low;
    @(negedge clk);
    check_pl("R7", !prev);  // divide-by-two toggles
    sel = 2'b00;
    periods(2, 0, 1, 0, 0);
    sel = 2'b01;
    periods(2, 0, 1, 0, 0);
    sel = 2'b10;
    periods(2, -1, 1, 0, 0);
    check_pl("R7", 1'b1);   // no pulse at period end

    cur_req = "R8";
    test_en = 0; sel = 2'b00;
    periods(5, 0, 0, 0, 0);
    check_pl("R8", 1'b0);
    sel = 2'b11;
    @(negedge clk);
    check_pl("R8", 1'b1);   // one clock after selection change

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule